// File: doc/BRIEF.md
# Step and Direction Source Selector with Edge Qualifier

This block sits in front of a stepper-motor indexer. It turns either a pair of external pins or a set of control-register bits into two signals: a one-clock step-advance pulse and a direction level. Step and direction each choose their source independently. The register step request arrives as a single-cycle write strobe, which models a register bit that clears itself after a 1 is written.

The pin path resynchronizes both pins through a two-flop chain. It then finds edges by comparing the synchronized level with the level one cycle earlier. The rising edge is always active. The falling edge is also counted only when the register interface is enabled and the both-edges control is set. Counting both edges doubles the step rate for a given pin toggle frequency. When the register interface is disabled, the register controls have no effect: the pins are used and only rising edges count.

Top module: `step_dir_select`

## Requirements
- R1: While `rst_ni` is low, `step_o` and `dir_o` are 0. After reset is released, no step pulse is produced for a step pin that was already high, until that pin actually changes level.
- R2: When the register interface is disabled, or `use_reg_dir_i` is 0, `dir_o` takes the level of `dir_pin_i` (1 = forward, 0 = reverse). A level that is stable before clock edge k appears on `dir_o` after edge k+2.
- R3: When `reg_if_en_i` and `use_reg_dir_i` are both 1, `dir_o` equals the value that `reg_dir_i` had at the previous clock edge.
- R4: When the pin step source is selected with the register interface enabled and `both_edges_i` = 0, a rising edge of `step_pin_i` produces exactly one `step_o` pulse, one clock wide. The pulse appears after edge k+2 when the new level is stable before edge k. A falling edge produces no pulse.
- R5: When `reg_if_en_i` = 1, `both_edges_i` = 1 and the pin step source is selected, each rising edge and each falling edge of `step_pin_i` produces one pulse, with the same latency as in R4.
- R6: When `reg_if_en_i` = 0, only rising edges of `step_pin_i` produce pulses, whatever the value of `both_edges_i`.
- R7: When `reg_if_en_i` and `use_reg_step_i` are both 1, each cycle in which `reg_step_wr_i` is 1 gives exactly one `step_o` pulse after the next clock edge. Pin edges produce no pulse in this mode, even when they coincide with a write.
- R8: When `use_reg_step_i` = 0, or `reg_if_en_i` = 0, `reg_step_wr_i` has no effect on `step_o`.
- R9: When the step and direction pins change in the same cycle, `dir_o` already shows the new direction in the cycle in which the resulting step pulse is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| step_pin_i | input | 1 | Raw step pin, asynchronous |
| dir_pin_i | input | 1 | Raw direction pin, asynchronous |
| reg_if_en_i | input | 1 | Register interface enabled; 0 forces the pins and rising-edge-only stepping |
| use_reg_step_i | input | 1 | 1 selects register step strobes as the step source |
| use_reg_dir_i | input | 1 | 1 selects `reg_dir_i` as the direction source |
| reg_dir_i | input | 1 | Register direction bit, 1 = forward |
| reg_step_wr_i | input | 1 | One-cycle strobe: a 1 was written to the self-clearing step bit |
| both_edges_i | input | 1 | 1 makes both step pin edges active (only while the register interface is enabled) |
| step_o | output | 1 | One-cycle step-advance pulse |
| dir_o | output | 1 | Effective direction, 1 = forward |

## Verification
A wrong synchronizer depth or a stale previous-level flop shows up at the ports as a step pulse one cycle early or late, or as a pulse on a falling edge. Either is visible within three cycles of the pin change. A mis-decoded source select shows up at once as a missing or extra pulse in the cycle after a register strobe, or as `dir_o` following the wrong input. A start-up counter that is absent or too short shows up as a spurious pulse within four cycles of reset release whenever the step pin is held high.

// File: rtl/sds_pkg.sv
package sds_pkg;
  localparam int SDS_SYNC_STAGES = 2;

  typedef enum logic {
    EDGE_RISE = 1'b0,
    EDGE_BOTH = 1'b1
  } edge_mode_e;
endpackage

// File: rtl/sds_sync.sv
module sds_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/sds_edge.sv
module sds_edge
  import sds_pkg::*;
#(
  parameter int FILL = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       lvl_i,
  input  edge_mode_e mode_i,
  output logic       evt_o
);
  localparam int CW = $clog2(FILL + 1);
  localparam logic [CW-1:0] FILL_C = CW'(FILL);

  logic [CW-1:0] fill_q;
  logic          prev_q;
  logic          armed;

  // hold off until both lvl_i and prev_q carry real pin samples
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fill_q <= '0;
      prev_q <= 1'b0;
    end else begin
      if (fill_q != FILL_C) fill_q <= fill_q + 1'b1;
      prev_q <= lvl_i;
    end
  end

  assign armed = (fill_q == FILL_C);

  always_comb begin
    unique case (mode_i)
      EDGE_BOTH: evt_o = armed & (lvl_i ^ prev_q);
      default:   evt_o = armed & lvl_i & ~prev_q;
    endcase
  end
endmodule

// File: rtl/step_dir_select.sv
module step_dir_select
  import sds_pkg::*;
#(
  parameter int SYNC_STAGES = SDS_SYNC_STAGES
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic step_pin_i,
  input  logic dir_pin_i,
  input  logic reg_if_en_i,
  input  logic use_reg_step_i,
  input  logic use_reg_dir_i,
  input  logic reg_dir_i,
  input  logic reg_step_wr_i,
  input  logic both_edges_i,
  output logic step_o,
  output logic dir_o
);
  localparam int NPIN = 2;
  localparam int PIN_STEP = 0;
  localparam int PIN_DIR = 1;

  logic [NPIN-1:0] pin_raw, pin_sync;
  logic            pin_evt;
  logic            sel_reg_step, sel_reg_dir;
  edge_mode_e      edge_mode;
  logic            step_d, dir_d;
  logic            step_q, dir_q;

  assign pin_raw[PIN_STEP] = step_pin_i;
  assign pin_raw[PIN_DIR]  = dir_pin_i;

  sds_sync #(.WIDTH(NPIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_raw),
    .q_o   (pin_sync)
  );

  // both-edge mode only exists while the register interface is on
  assign edge_mode = (reg_if_en_i && both_edges_i) ? EDGE_BOTH : EDGE_RISE;

  sds_edge #(.FILL(SYNC_STAGES + 1)) u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (pin_sync[PIN_STEP]),
    .mode_i(edge_mode),
    .evt_o (pin_evt)
  );

  assign sel_reg_step = reg_if_en_i & use_reg_step_i;
  assign sel_reg_dir  = reg_if_en_i & use_reg_dir_i;

  assign step_d = sel_reg_step ? reg_step_wr_i : pin_evt;
  assign dir_d  = sel_reg_dir ? reg_dir_i : pin_sync[PIN_DIR];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q <= 1'b0;
      dir_q  <= 1'b0;
    end else begin
      step_q <= step_d;
      dir_q  <= dir_d;
    end
  end

  assign step_o = step_q;
  assign dir_o  = dir_q;
endmodule

// File: rtl/sds_checker.sv
module sds_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic step_pin_i,
  input logic dir_pin_i,
  input logic reg_if_en_i,
  input logic use_reg_step_i,
  input logic use_reg_dir_i,
  input logic reg_dir_i,
  input logic reg_step_wr_i,
  input logic both_edges_i,
  input logic step_o,
  input logic dir_o
);
  logic [2:0] cyc_q;
  logic       hist_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cyc_q <= '0;
    else if (cyc_q != 3'd6) cyc_q <= cyc_q + 3'd1;
  end

  assign hist_ok = (cyc_q >= 3'd5);

  AST_DIR_FROM_PIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hist_ok && !$past(reg_if_en_i)) |-> (dir_o == $past(dir_pin_i, 3)));  // R2

  AST_DIR_FROM_REG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_if_en_i && use_reg_dir_i) |=> (dir_o == $past(reg_dir_i)));  // R3

  AST_REG_STEP_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_if_en_i && use_reg_step_i) |=> (step_o == $past(reg_step_wr_i)));  // R7

  AST_HW_RISE_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hist_ok && !$past(reg_if_en_i) && step_o) |->
      ($past(step_pin_i, 3) && !$past(step_pin_i, 4)));  // R6
endmodule

bind step_dir_select sds_checker u_chk (.*);

// File: tb/sim_step_dir_select.sv
module sim_step_dir_select;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic step_pin = 1'b0, dir_pin = 1'b0;
  logic en = 1'b0, use_step = 1'b0, use_dir = 1'b0;
  logic rdir = 1'b0, wr = 1'b0, both = 1'b0;
  logic step_o, dir_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  int ncyc = 0;
  logic [3:1] sp_h = '0;
  logic [2:1] dp_h = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  step_dir_select u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .step_pin_i(step_pin), .dir_pin_i(dir_pin),
    .reg_if_en_i(en), .use_reg_step_i(use_step), .use_reg_dir_i(use_dir),
    .reg_dir_i(rdir), .reg_step_wr_i(wr), .both_edges_i(both),
    .step_o(step_o), .dir_o(dir_o)
  );

  task automatic chk(string tag, string what, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic logic exp_step_f(int n, logic [3:1] h);
    if (en && use_step) return wr;
    if (n < 4) return 1'b0;
    if (en && both) return h[2] ^ h[3];
    return h[2] & ~h[3];
  endfunction

  function automatic logic exp_dir_f(logic [2:1] h);
    return (en && use_dir) ? rdir : h[2];
  endfunction

  task automatic tick(string tag);
    logic es, ed;
    string ts, td;
    ncyc++;
    es = exp_step_f(ncyc, sp_h);
    ed = exp_dir_f(dp_h);
    ts = (en && use_step) ? "R7" : ((en && both) ? "R5" : (en ? "R4" : "R6"));
    td = (en && use_dir) ? "R3" : "R2";
    if (tag != "") begin ts = tag; td = tag; end
    sp_h = {sp_h[2:1], step_pin};
    dp_h = {dp_h[1], dir_pin};
    @(posedge clk);
    #(CLK_PERIOD/4);
    chk(ts, "step_o", step_o, es);
    chk(td, "dir_o", dir_o, ed);
  endtask

  task automatic ticks(string tag, int k);
    for (int i = 0; i < k; i++) tick(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R4 watchdog expired actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    // R1: reset with step pin already high
    step_pin = 1'b1;
    dir_pin = 1'b1;
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/4);
    chk("R1", "step_o in reset", step_o, 1'b0);
    chk("R1", "dir_o in reset", dir_o, 1'b0);
    rst_n = 1'b1;
    ticks("R1", 6);

    // R4: rising edges only, register interface on
    en = 1'b1;
    step_pin = 1'b0; ticks("R4", 4);
    step_pin = 1'b1; ticks("R4", 4);
    step_pin = 1'b0; ticks("R4", 4);

    // R5: both edges
    both = 1'b1;
    step_pin = 1'b1; ticks("R5", 4);
    step_pin = 1'b0; ticks("R5", 4);
    step_pin = 1'b1; ticks("R5", 1);
    step_pin = 1'b0; ticks("R5", 4);

    // R6: interface off, both_edges ignored
    en = 1'b0;
    step_pin = 1'b1; ticks("R6", 4);
    step_pin = 1'b0; ticks("R6", 4);

    // R8: strobes ignored when not selected
    wr = 1'b1; ticks("R8", 3);
    use_step = 1'b1; ticks("R8", 3);
    en = 1'b1; use_step = 1'b0; ticks("R8", 3);
    wr = 1'b0;

    // R7: register strobes, pin edges ignored
    use_step = 1'b1; both = 1'b0;
    wr = 1'b1; step_pin = 1'b1; ticks("R7", 1);
    wr = 1'b0; ticks("R7", 4);
    wr = 1'b1; ticks("R7", 2);
    step_pin = 1'b0; wr = 1'b0; ticks("R7", 4);

    // R3 / R2: direction sources
    use_dir = 1'b1; rdir = 1'b1; ticks("R3", 2);
    rdir = 1'b0; dir_pin = 1'b1; ticks("R3", 2);
    use_dir = 1'b0; ticks("R2", 3);
    dir_pin = 1'b0; ticks("R2", 4);

    // R9: step and direction pins change together
    use_step = 1'b0; en = 1'b0;
    dir_pin = 1'b0; step_pin = 1'b0; ticks("R9", 4);
    dir_pin = 1'b1; step_pin = 1'b1; ticks("R9", 4);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(3) == 0) step_pin = ~step_pin;
      if ($urandom_range(7) == 0) dir_pin = ~dir_pin;
      if ($urandom_range(15) == 0) en = ~en;
      if ($urandom_range(15) == 0) use_step = ~use_step;
      if ($urandom_range(15) == 0) use_dir = ~use_dir;
      if ($urandom_range(15) == 0) both = ~both;
      rdir = 1'($urandom_range(1));
      wr = ($urandom_range(2) == 0);
      tick("");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule